// File: doc/BRIEF.md
# Energy Counter Delta Integrator

This block turns periodic samples of a 20-bit up/down energy counter that wraps around into a running signed energy total and a train of one-clock pulses. Each accepted sample is compared with the one kept from before. The signed wrapped difference is that period's quantum. The quantum is not added in one step. It is dealt into a fractional accumulator as equal slices, one on each sub-tick strobe. The part that does not divide evenly is added once per period. Output pulses therefore land on a grid sixteen times finer than the sampling period.

Whenever the fraction reaches the programmable threshold `thr_i` (or falls to its negative), one unit moves into the integer total. The threshold is taken out of, or put back into, the fraction, and a pulse is emitted with a direction flag. A sample flagged as bad contributes a zero quantum and leaves the stored sample as it was. The first good sample after reset only seeds the stored value.

Top module: `energy_delta_integ`

## Requirements
- R1: While `rst_ni` is low and after its release, `total_o` is 0, `pulse_o` is 0 and `dir_rev_o` is 0.
- R2: The first sample with `valid_i`=1 and `ok_i`=1 after reset only stores the sample. Its quantum is zero.
- R3: For later good samples, quantum = (new − old) mod 2^20, sign-extended from bit 19. The stored sample is then replaced by the new one.
- R4: A sample with `valid_i`=1 and `ok_i`=0 yields a zero quantum and leaves the stored sample unchanged.
- R5: A sample taken at clock edge k sets the slice to floor(quantum/16) (arithmetic shift right by 4). It also adds the remainder quantum mod 16 (0..15) to the fraction once, at edge k+1. Each `tick_i` adds the slice to the fraction. A tick at edge k+1 still uses the previous slice.
- R6: If fraction+addend ≥ `thr_i`, the fraction becomes fraction+addend−`thr_i`, `total_o` rises by one, `pulse_o` is high for that clock and `dir_rev_o` becomes 0. There is at most one step per clock, and any excess carries over.
- R7: Otherwise, if fraction+addend ≤ −`thr_i`, the fraction becomes fraction+addend+`thr_i`, `total_o` falls by one, `pulse_o` is high for that clock and `dir_rev_o` becomes 1.
- R8: `pulse_o` is high in exactly the cycles in which `total_o` changes. `dir_rev_o` keeps the direction of the last step.
- R9: The fraction and `total_o` are 32-bit signed, and `total_o` wraps modulo 2^32. `thr_i` is taken as an unsigned value and must be nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reading_i | input | 20 | Energy counter sample |
| valid_i | input | 1 | Sample present this clock |
| ok_i | input | 1 | Sample passed integrity checks |
| tick_i | input | 1 | Sub-tick strobe |
| thr_i | input | 32 | Step threshold, positive |
| total_o | output | 32 | Signed integer energy total |
| dir_rev_o | output | 1 | Direction of the last step, 1 = reverse |
| pulse_o | output | 1 | One-clock pulse per step |

## Verification
Outputs are registered. A tick at edge k changes `total_o` and `pulse_o` at edge k, using the slice that was in place before that edge. A sample at edge k reaches the fraction through its remainder at edge k+1, and through its slice from the first tick after edge k+1. The bench models this two-stage pipeline with integers and compares all three outputs a quarter period after every rising edge. Directed scenarios then check hand-computed totals after each block of sixteen ticks. These scenarios cover priming, a negative quantum, a wrap across zero, a bad sample, and a quantum carried only in its remainder.

// File: rtl/energy_integ_pkg.sv
package energy_integ_pkg;
  localparam int unsigned CNT_W_DEF   = 20;
  localparam int unsigned ACC_W_DEF   = 32;
  localparam int unsigned SLICE_L_DEF = 4;
endpackage

// File: rtl/edi_delta.sv
module edi_delta #(
  parameter int unsigned CNT_W = energy_integ_pkg::CNT_W_DEF,
  parameter int unsigned ACC_W = energy_integ_pkg::ACC_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        reading_i,
  input  logic                    valid_i,
  input  logic                    ok_i,
  output logic                    upd_o,
  output logic signed [ACC_W-1:0] quant_o
);
  localparam int unsigned EXT_W = ACC_W - CNT_W;

  logic [CNT_W-1:0] old_q;
  logic             primed_q;
  logic [CNT_W-1:0] diff;

  // modulo-2^CNT_W difference, sign taken from its top bit
  assign diff = reading_i - old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q    <= '0;
      primed_q <= 1'b0;
      upd_o    <= 1'b0;
      quant_o  <= '0;
    end else begin
      upd_o <= valid_i;
      if (valid_i) begin
        if (ok_i && primed_q) begin
          quant_o <= {{EXT_W{diff[CNT_W-1]}}, diff};
          old_q   <= reading_i;
        end else if (ok_i) begin
          quant_o  <= '0;
          old_q    <= reading_i;
          primed_q <= 1'b1;
        end else begin
          quant_o <= '0;
        end
      end
    end
  end

  a_r4_bad_keeps_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ok_i) |=> $stable(old_q));
  a_r4_bad_zero_quant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ok_i) |=> (quant_o == '0));
  a_r2_prime_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(primed_q) |-> (quant_o == '0));
endmodule

// File: rtl/edi_slicer.sv
module edi_slicer #(
  parameter int unsigned ACC_W   = energy_integ_pkg::ACC_W_DEF,
  parameter int unsigned SLICE_L = energy_integ_pkg::SLICE_L_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [ACC_W-1:0] quant_i,
  input  logic                    tick_i,
  output logic signed [ACC_W-1:0] addend_o
);
  logic signed [ACC_W-1:0] slice_q;
  logic signed [ACC_W-1:0] rem_ext;
  logic signed [ACC_W-1:0] slice_add;

  assign rem_ext   = {{(ACC_W-SLICE_L){1'b0}}, quant_i[SLICE_L-1:0]};
  assign slice_add = tick_i ? slice_q : '0;
  assign addend_o  = slice_add + (upd_i ? rem_ext : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    slice_q <= '0;
    else if (upd_i) slice_q <= quant_i >>> SLICE_L;
  end

  a_r5_slice_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(slice_q));
endmodule

// File: rtl/edi_accum.sv
module edi_accum #(
  parameter int unsigned ACC_W = energy_integ_pkg::ACC_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] addend_i,
  input  logic [ACC_W-1:0]        thr_i,
  output logic signed [ACC_W-1:0] total_o,
  output logic                    pulse_o,
  output logic                    dir_rev_o
);
  logic signed [ACC_W-1:0] frac_q;
  logic signed [ACC_W:0]   sum, thr_p, thr_n;
  logic                    up, dn;

  assign sum   = {frac_q[ACC_W-1], frac_q} + {addend_i[ACC_W-1], addend_i};
  assign thr_p = {1'b0, thr_i};
  assign thr_n = -thr_p;
  assign up    = (sum >= thr_p);
  assign dn    = !up && (sum <= thr_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q    <= '0;
      total_o   <= '0;
      pulse_o   <= 1'b0;
      dir_rev_o <= 1'b0;
    end else begin
      pulse_o <= up | dn;
      if (up) begin
        frac_q    <= ACC_W'(sum - thr_p);
        total_o   <= total_o + 1'b1;
        dir_rev_o <= 1'b0;
      end else if (dn) begin
        frac_q    <= ACC_W'(sum + thr_p);
        total_o   <= total_o - 1'b1;
        dir_rev_o <= 1'b1;
      end else begin
        frac_q <= ACC_W'(sum);
      end
    end
  end

  a_r8_pulse_iff_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o == (total_o != $past(total_o)));
  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_o != $past(total_o)) |->
      (total_o == $past(total_o) + 1 || total_o == $past(total_o) - 1));
  a_r7_dir_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && total_o == $past(total_o) - 1) |-> dir_rev_o);
  a_r6_dir_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && total_o == $past(total_o) + 1) |-> !dir_rev_o);
  a_r8_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> $stable(dir_rev_o));
endmodule

// File: rtl/energy_delta_integ.sv
module energy_delta_integ #(
  parameter int unsigned CNT_W   = energy_integ_pkg::CNT_W_DEF,
  parameter int unsigned ACC_W   = energy_integ_pkg::ACC_W_DEF,
  parameter int unsigned SLICE_L = energy_integ_pkg::SLICE_L_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        reading_i,
  input  logic                    valid_i,
  input  logic                    ok_i,
  input  logic                    tick_i,
  input  logic [ACC_W-1:0]        thr_i,
  output logic signed [ACC_W-1:0] total_o,
  output logic                    dir_rev_o,
  output logic                    pulse_o
);
  logic                    upd;
  logic signed [ACC_W-1:0] quant;
  logic signed [ACC_W-1:0] addend;

  edi_delta #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_delta (
    .clk_i, .rst_ni, .reading_i, .valid_i, .ok_i,
    .upd_o(upd), .quant_o(quant)
  );

  edi_slicer #(.ACC_W(ACC_W), .SLICE_L(SLICE_L)) u_slicer (
    .clk_i, .rst_ni, .upd_i(upd), .quant_i(quant), .tick_i,
    .addend_o(addend)
  );

  edi_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i, .rst_ni, .addend_i(addend), .thr_i,
    .total_o, .pulse_o, .dir_rev_o
  );
endmodule

// File: tb/energy_delta_integ_tb.sv
module energy_delta_integ_tb;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic        clk = 0, rst_n = 0;
  logic [19:0] reading = '0;
  logic        valid = 0, ok = 0, tick = 0;
  logic [31:0] thr = 32'd32;
  logic signed [31:0] total;
  logic        dir_rev, pulse;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  longint m_frac = 0, m_slice = 0, m_q = 0;
  int     m_total = 0;
  bit     m_pulse = 0, m_dir = 0, m_upd = 0, m_primed = 0;
  int     m_old = 0;

  energy_delta_integ u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reading_i(reading), .valid_i(valid),
    .ok_i(ok), .tick_i(tick), .thr_i(thr), .total_o(total),
    .dir_rev_o(dir_rev), .pulse_o(pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      longint add, s, t;
      int d;
      add = 0;
      if (m_upd) add += (m_q & 15);
      if (tick)  add += m_slice;
      if (m_upd) m_slice = m_q >>> 4;
      s = m_frac + add;
      t = longint'(thr);
      m_pulse = 0;
      if (s >= t)       begin m_frac = s - t; m_total++; m_pulse = 1; m_dir = 0; end
      else if (s <= -t) begin m_frac = s + t; m_total--; m_pulse = 1; m_dir = 1; end
      else m_frac = s;
      m_upd = valid;
      if (valid) begin
        if (ok && m_primed) begin
          d = (int'(reading) - m_old) & 32'hFFFFF;
          if (d >= 32'h80000) d -= 32'h100000;
          m_q = d; m_old = int'(reading);
        end else if (ok) begin
          m_q = 0; m_old = int'(reading); m_primed = 1;
        end else m_q = 0;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // R5 R6 R7 R8: continuous comparison against the model
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk({tag, " total"}, total, m_total);
      chk({tag, " pulse"}, pulse, m_pulse);
      chk({tag, " dir"},   dir_rev, m_dir);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(logic [19:0] r, bit good);
    @(negedge clk); reading = r; valid = 1; ok = good;
    @(negedge clk); valid = 0; ok = 0;
    idle(2);
  endtask

  task automatic ticks16();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      idle(1);
    end
    idle(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    idle(3);
    chk("R1 total in reset", total, 0);
    chk("R1 pulse in reset", pulse, 0);
    chk("R1 dir in reset", dir_rev, 0);
    rst_n = 1;
    idle(2);
    chk("R1 total after reset", total, 0);

    tag = "R2";
    sample(20'h00100, 1);
    ticks16();
    chk("R2 prime adds nothing", total, 0);

    tag = "R6";
    sample(20'h00140, 1);
    ticks16();
    chk("R6 positive steps", total, 2);
    chk("R6 dir forward", dir_rev, 0);

    tag = "R7";
    sample(20'hFFFF0, 1);
    ticks16();
    chk("R7 R3 negative quantum", total, -8);
    chk("R7 dir reverse", dir_rev, 1);

    tag = "R3";
    sample(20'h00020, 1);
    ticks16();
    chk("R3 wrap across zero", total, -7);
    chk("R3 dir forward again", dir_rev, 0);

    tag = "R4";
    sample(20'h50000, 0);
    ticks16();
    chk("R4 bad sample no effect", total, -7);
    sample(20'h00031, 1);
    ticks16();
    chk("R4 old kept after bad sample", total, -7);

    tag = "R5";
    sample(20'h00040, 1);
    idle(3);
    chk("R5 remainder added once", total, -6);

    // R9: mixed random traffic, threshold changes, compared each clock
    tag = "R9";
    for (int k = 0; k < 200; k++) begin
      int dlt;
      @(negedge clk);
      thr = 32'd16 + ($urandom % 4000);
      dlt = int'($urandom % 6001) - 3000;
      reading = reading + 20'(dlt);
      valid = 1; ok = (($urandom % 5) != 0);
      @(negedge clk); valid = 0; ok = 0;
      for (int i = 0; i < 16; i++) begin
        tick = 1; @(negedge clk); tick = 0;
        idle($urandom % 3);
      end
    end
    idle(4);
    finish_run();
  end
endmodule